// File: doc/BRIEF.md
# Multi-Image FPGA Configuration Loader

This block is the configuration controller that sits next to an FPGA on a board. It fetches one of several bitstream images held in a parallel NOR flash and pushes it, one byte at a time, into the FPGA through a byte-wide passive parallel configuration port. Each image occupies a slot. The flash base address of a slot is computed from two parameters: a first-slot base and a slot stride. Every image has the same fixed byte length.

After power-up the controller loads the safe image in slot 0 with no prompt. From then on the FPGA chooses what happens next. It places a slot number on its select pins and pulses a request line, and the controller reloads the FPGA from that slot.

Each attempt is judged from the FPGA's status and done inputs. When an attempt on an ordinary slot fails, the controller reloads the safe image and raises a fallback flag. When the safe image itself fails, the controller sets a sticky fatal flag and does nothing more until it is reset.

Top module: `cfg_loader`

## Requirements
- R1: After `rst` is released, the controller loads slot 0 without any request. During reset, `cfg_nrst` is 0, `busy` is 1, `fatal` is 0 and `cfg_clk` is 0. When that load succeeds, `busy` drops, `cur_img` is 0 and `fell_back` is 0.
- R2: Each attempt begins with `cfg_nrst` held low for at least RST_CYC cycles. After release, no `cfg_clk` rising edge occurs until `cfg_status` has been seen high. `cfg_clk` is only ever high while `cfg_nrst` is high.
- R3: For slot s, byte i (0 ≤ i < IMG_LEN) is read from flash address BASE0 + s·STRIDE + i. Bytes go out in increasing i. Each byte is set up on `cfg_data` one cycle before `cfg_clk` rises, and `cfg_clk` stays high for exactly one cycle per byte.
- R4: A flash byte is taken only after `fl_oe` has been high and `fl_addr` unchanged for FL_LAT cycles.
- R5: While the FPGA is in user mode (`busy` = 0, `fatal` = 0), a cycle with `req` = 1 captures `req_img` in that same cycle and starts a load of that slot. On success, `cur_img` becomes that slot.
- R6: `req` has no effect while `busy` = 1 or `fatal` = 1. The slot being loaded does not change, and no new attempt begins.
- R7: If `cfg_status` goes low while bytes are being sent or while waiting for done, the attempt fails immediately and no further byte is clocked.
- R8: After the last byte, `cfg_done` high within DONE_WIN cycles means success. Otherwise the attempt fails.
- R9: When an attempt on a slot other than 0 fails, slot 0 is loaded next and `fell_back` is set. `cur_img` reads 0 after that recovery. The next accepted request clears `fell_back`.
- R10: When an attempt on slot 0 fails, `fatal` is set and stays set. `busy` goes low and no further attempt starts.
- R11: A reset clears `fatal` and restarts the power-up load of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Reconfigure request from the FPGA |
| req_img | input | IDX_W | Slot number chosen by the FPGA |
| fl_addr | output | ADDR_W | Flash read address |
| fl_oe | output | 1 | Flash read enable |
| fl_data | input | 8 | Flash read data |
| cfg_nrst | output | 1 | Configuration reset to the FPGA, active low |
| cfg_status | input | 1 | FPGA ready/status, high = ready, low = error |
| cfg_done | input | 1 | FPGA configuration done |
| cfg_clk | output | 1 | Configuration byte clock |
| cfg_data | output | 8 | Configuration data byte |
| busy | output | 1 | A load attempt is in progress |
| cur_img | output | IDX_W | Slot currently loaded and running |
| fell_back | output | 1 | The last requested slot failed and slot 0 was loaded instead |
| fatal | output | 1 | The safe image failed; sticky until reset |

## Verification
The loader is exercised with several target behaviours, each separating one decision path from the others:
- **Well-behaved target:** accepts every slot and confirms the byte order, addressing and flash-latency timing.
- **Target that never signals done on one slot:** shows that the done window leads to fallback and not to a hang.
- **Target that signals done too late:** distinguishes a window that is honoured from one that is ignored.
- **Target that pulls status low partway through an image:** shows that streaming stops at once and recovery begins.
- **Double failure, then reset:** failing both a requested slot and the safe slot separates fallback from the fatal state. The reset that follows shows recovery.
- **Requests outside user mode:** raised while busy and while fatal, they show that such requests are ignored.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  typedef enum logic [2:0] {
    S_HOLD,
    S_WSTAT,
    S_STREAM,
    S_WDONE,
    S_USER,
    S_FATAL
  } seq_st_e;

  typedef enum logic [1:0] {
    P_IDLE,
    P_ADDR,
    P_SETUP,
    P_HIGH
  } byte_ph_e;

endpackage

// File: rtl/cfg_byte_engine.sv
module cfg_byte_engine
  import cfg_ldr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IMG_LEN = 16,
  parameter int FL_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_oe,
  input  logic [7:0]        fl_data,
  output logic [7:0]        cfg_data,
  output logic              cfg_clk,
  output logic              last
);

  localparam int OFS_W = $clog2(IMG_LEN + 1);
  localparam int LAT_W = $clog2(FL_LAT + 1);

  byte_ph_e         ph;
  logic [OFS_W-1:0] ofs;
  logic [LAT_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      ph       <= P_IDLE;
      ofs      <= '0;
      wcnt     <= '0;
      fl_oe    <= 1'b0;
      fl_addr  <= '0;
      cfg_data <= '0;
      cfg_clk  <= 1'b0;
      last     <= 1'b0;
    end else begin
      last <= 1'b0;
      case (ph)
        P_IDLE: begin
          if (start) begin
            ph      <= P_ADDR;
            ofs     <= '0;
            wcnt    <= '0;
            fl_oe   <= 1'b1;
            fl_addr <= base;
          end
        end
        P_ADDR: begin
          // wait out the flash access time, then latch the byte
          if (wcnt == LAT_W'(FL_LAT - 1)) begin
            cfg_data <= fl_data;
            wcnt     <= '0;
            ph       <= P_SETUP;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        P_SETUP: begin
          cfg_clk <= 1'b1;
          ph      <= P_HIGH;
        end
        P_HIGH: begin
          cfg_clk <= 1'b0;
          if (ofs == OFS_W'(IMG_LEN - 1)) begin
            ph    <= P_IDLE;
            fl_oe <= 1'b0;
            last  <= 1'b1;
          end else begin
            ofs     <= ofs + 1'b1;
            fl_addr <= base + ADDR_W'(ofs) + ADDR_W'(1);
            ph      <= P_ADDR;
          end
        end
        default: ph <= P_IDLE;
      endcase
    end
  end

  // R3: one configuration clock cycle per byte
  assert_clk_pulse_R3 : assert property (@(posedge clk) disable iff (rst)
    cfg_clk |=> !cfg_clk);

  // R3: data already settled when the clock rises
  assert_data_setup_R3 : assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_clk) |-> $stable(cfg_data));

  // R4: address held while the byte is taken
  assert_addr_hold_R4 : assert property (@(posedge clk) disable iff (rst)
    (ph == P_SETUP) |-> ($stable(fl_addr) && fl_oe));

  // R3: byte offset never leaves the image
  assert_ofs_range_R3 : assert property (@(posedge clk) disable iff (rst)
    ofs < OFS_W'(IMG_LEN));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_ldr_pkg::*;
#(
  parameter int IDX_W    = 2,
  parameter int RST_CYC  = 4,
  parameter int DONE_WIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] req_img,
  input  logic             cfg_status,
  input  logic             cfg_done,
  input  logic             eng_last,
  output logic [IDX_W-1:0] slot,
  output logic             eng_start,
  output logic             eng_abort,
  output logic             cfg_nrst,
  output logic             busy,
  output logic [IDX_W-1:0] cur_img,
  output logic             fell_back,
  output logic             fatal
);

  localparam int CNT_MAX = (RST_CYC > DONE_WIN) ? RST_CYC : DONE_WIN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic             att_fail;
  logic             att_ok;

  always_comb begin
    att_fail = 1'b0;
    att_ok   = 1'b0;
    case (st)
      S_STREAM: att_fail = !cfg_status;
      S_WDONE: begin
        if (!cfg_status)                          att_fail = 1'b1;
        else if (cfg_done)                        att_ok   = 1'b1;
        else if (cnt == CNT_W'(DONE_WIN - 1))     att_fail = 1'b1;
      end
      default: ;
    endcase
  end

  assign eng_abort = att_fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HOLD;
      cnt       <= '0;
      slot      <= '0;
      cfg_nrst  <= 1'b0;
      busy      <= 1'b1;
      cur_img   <= '0;
      fell_back <= 1'b0;
      fatal     <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      if (att_fail) begin
        if (slot == '0) begin
          st    <= S_FATAL;
          fatal <= 1'b1;
          busy  <= 1'b0;
        end else begin
          slot      <= '0;
          fell_back <= 1'b1;
          st        <= S_HOLD;
          cnt       <= '0;
          cfg_nrst  <= 1'b0;
        end
      end else if (att_ok) begin
        st      <= S_USER;
        busy    <= 1'b0;
        cur_img <= slot;
      end else begin
        case (st)
          S_HOLD: begin
            if (cnt == CNT_W'(RST_CYC - 1)) begin
              cnt      <= '0;
              cfg_nrst <= 1'b1;
              st       <= S_WSTAT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WSTAT: begin
            if (cfg_status) begin
              st        <= S_STREAM;
              eng_start <= 1'b1;
            end
          end
          S_STREAM: begin
            if (eng_last) begin
              st  <= S_WDONE;
              cnt <= '0;
            end
          end
          S_WDONE: cnt <= cnt + 1'b1;
          S_USER: begin
            if (req) begin
              slot      <= req_img;
              fell_back <= 1'b0;
              busy      <= 1'b1;
              cnt       <= '0;
              cfg_nrst  <= 1'b0;
              st        <= S_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: fatal is sticky until reset
  assert_fatal_sticky_R10 : assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);

  // R10: a fatal controller starts nothing
  assert_fatal_quiet_R10 : assert property (@(posedge clk) disable iff (rst)
    fatal |-> (!busy && cfg_nrst));

  // R9: after fallback the running image is the safe one
  assert_fallback_safe_R9 : assert property (@(posedge clk) disable iff (rst)
    (fell_back && !busy) |-> (cur_img == '0));

  // R6: a request during a load leaves the target slot alone
  assert_req_ignored_R6 : assert property (@(posedge clk) disable iff (rst)
    (busy && req && !att_fail) |=> $stable(slot));

  // R2: configuration reset only asserted as part of a load
  assert_nrst_busy_R2 : assert property (@(posedge clk) disable iff (rst)
    !cfg_nrst |-> busy);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int              IDX_W    = 2,
  parameter int              ADDR_W   = 16,
  parameter int              IMG_LEN  = 16,
  parameter logic [ADDR_W-1:0] BASE0  = 16'h0100,
  parameter logic [ADDR_W-1:0] STRIDE = 16'h0400,
  parameter int              RST_CYC  = 4,
  parameter int              FL_LAT   = 3,
  parameter int              DONE_WIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [IDX_W-1:0]  req_img,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_oe,
  input  logic [7:0]        fl_data,
  output logic              cfg_nrst,
  input  logic              cfg_status,
  input  logic              cfg_done,
  output logic              cfg_clk,
  output logic [7:0]        cfg_data,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_img,
  output logic              fell_back,
  output logic              fatal
);

  logic [IDX_W-1:0]  slot;
  logic              eng_start;
  logic              eng_abort;
  logic              eng_last;
  logic [ADDR_W-1:0] img_base;

  // slot base computed, no stored table
  assign img_base = BASE0 + ADDR_W'(slot) * STRIDE;

  cfg_seq_ctrl #(
    .IDX_W    (IDX_W),
    .RST_CYC  (RST_CYC),
    .DONE_WIN (DONE_WIN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_img    (req_img),
    .cfg_status (cfg_status),
    .cfg_done   (cfg_done),
    .eng_last   (eng_last),
    .slot       (slot),
    .eng_start  (eng_start),
    .eng_abort  (eng_abort),
    .cfg_nrst   (cfg_nrst),
    .busy       (busy),
    .cur_img    (cur_img),
    .fell_back  (fell_back),
    .fatal      (fatal)
  );

  cfg_byte_engine #(
    .ADDR_W  (ADDR_W),
    .IMG_LEN (IMG_LEN),
    .FL_LAT  (FL_LAT)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (eng_start),
    .abort    (eng_abort),
    .base     (img_base),
    .fl_addr  (fl_addr),
    .fl_oe    (fl_oe),
    .fl_data  (fl_data),
    .cfg_data (cfg_data),
    .cfg_clk  (cfg_clk),
    .last     (eng_last)
  );

  // R2: no byte clock while the target is held in configuration reset
  assert_clk_after_release_R2 : assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> cfg_nrst);

  // R7: a dropped status never sees another byte clock
  assert_no_clk_on_error_R7 : assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_nrst && !cfg_status && !cfg_clk) |=> !cfg_clk);

endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;

  localparam int              IDX_W    = 2;
  localparam int              ADDR_W   = 16;
  localparam int              IMG_LEN  = 16;
  localparam logic [15:0]     BASE0    = 16'h0100;
  localparam logic [15:0]     STRIDE   = 16'h0400;
  localparam int              RST_CYC  = 4;
  localparam int              FL_LAT   = 3;
  localparam int              DONE_WIN = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req = 1'b0;
  logic [IDX_W-1:0]  req_img = '0;
  logic [ADDR_W-1:0] fl_addr;
  logic              fl_oe;
  logic [7:0]        fl_data = 8'h00;
  logic              cfg_nrst;
  logic              cfg_status = 1'b0;
  logic              cfg_done = 1'b0;
  logic              cfg_clk;
  logic [7:0]        cfg_data;
  logic              busy;
  logic [IDX_W-1:0]  cur_img;
  logic              fell_back;
  logic              fatal;

  always #2.5 clk = ~clk;

  cfg_loader #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .IMG_LEN(IMG_LEN), .BASE0(BASE0),
    .STRIDE(STRIDE), .RST_CYC(RST_CYC), .FL_LAT(FL_LAT), .DONE_WIN(DONE_WIN)
  ) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_img(req_img),
    .fl_addr(fl_addr), .fl_oe(fl_oe), .fl_data(fl_data),
    .cfg_nrst(cfg_nrst), .cfg_status(cfg_status), .cfg_done(cfg_done),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .busy(busy), .cur_img(cur_img),
    .fell_back(fell_back), .fatal(fatal)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    int off, s;
    if (a < BASE0) return 8'hA5;
    off = int'(a - BASE0);
    s   = off / int'(STRIDE);
    if (s < 4 && (off % int'(STRIDE)) < IMG_LEN)
      return {4'(s), 4'(off % int'(STRIDE))};
    return 8'hA5;
  endfunction

  // driver side of the scoreboard: expected byte stream of one slot
  task automatic push_img(input int s, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(pat(BASE0 + 16'(s) * STRIDE + 16'(i)));
  endtask

  // target model knobs
  bit bad_done[4];
  bit late_done[4];
  bit bad_stat[4];

  // flash and target model, updated away from the active edge
  int         fl_st = 0;
  logic [15:0] fl_prev = '0;
  int  low_len = 0, stc = 0, rx = 0, dcnt = 0, dly = 0, cur_s = 0, falls = 0;
  bit  dropped = 0, dpend = 0;
  logic clk_prev = 1'b0, nrst_prev = 1'b1;
  logic [7:0] e;

  always @(negedge clk) begin
    if (fl_oe === 1'b1 && fl_addr == fl_prev && fl_st > 0) fl_st++;
    else if (fl_oe === 1'b1) fl_st = 1;
    else fl_st = 0;
    fl_prev = fl_addr;
    fl_data = (fl_st >= FL_LAT) ? pat(fl_addr) : 8'hEE;

    if (cfg_nrst === 1'b0 && nrst_prev === 1'b1) falls++;
    if (cfg_nrst === 1'b0) begin
      cfg_status = 0; cfg_done = 0; stc = 0; rx = 0; dropped = 0; dpend = 0;
      low_len++;
    end else if (cfg_nrst === 1'b1) begin
      if (low_len > 0) begin
        chk(low_len >= RST_CYC, "R2 reset hold length", low_len, RST_CYC);
        low_len = 0;
      end
      if (!dropped && !cfg_status) begin
        stc++;
        if (stc >= 3) cfg_status = 1;
      end
      if (cfg_clk === 1'b1 && clk_prev === 1'b0) begin
        chk(cfg_status, "R2 byte clocked before status high", 0, 1);
        if (exp_q.size() == 0) begin
          chk(0, "R3/R6 unexpected byte", cfg_data, 0);
        end else begin
          e = exp_q.pop_front();
          chk(cfg_data == e, "R3/R4 byte value", cfg_data, e);
        end
        if (rx == 0) cur_s = int'(cfg_data[7:4]) % 4;
        if (bad_stat[cur_s] && rx == 4) begin cfg_status = 0; dropped = 1; end
        if (rx == IMG_LEN - 1) begin
          dpend = !bad_done[cur_s];
          dcnt  = 0;
          dly   = late_done[cur_s] ? DONE_WIN + 6 : 2;
        end
        rx++;
      end
      if (dpend) begin
        dcnt++;
        if (dcnt >= dly) begin cfg_done = 1; dpend = 0; end
      end
    end
    clk_prev  = cfg_clk;
    nrst_prev = cfg_nrst;
  end

  // watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected run to end", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_settle(input string tag);
    int t = 0;
    while (busy === 1'b1 && fatal !== 1'b1 && t < 3000) begin
      @(negedge clk); t++;
    end
    chk(t < 3000, tag, t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_req(input int s);
    @(negedge clk);
    req = 1; req_img = IDX_W'(s);
    @(negedge clk);
    req = 0;
  endtask

  task automatic chk_state(input string tag, input int img, input bit fb, input bit ft);
    chk(cur_img == IDX_W'(img), {tag, " cur_img"}, cur_img, img);
    chk(fell_back == fb, {tag, " fell_back"}, fell_back, fb);
    chk(fatal == ft, {tag, " fatal"}, fatal, ft);
    chk(exp_q.size() == 0, {tag, " bytes left"}, exp_q.size(), 0);
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_nrst == 0, "R1 reset nrst", cfg_nrst, 0);
    chk(busy == 1, "R1 reset busy", busy, 1);
    chk(fatal == 0, "R1 reset fatal", fatal, 0);
    chk(cfg_clk == 0, "R1 reset cfg_clk", cfg_clk, 0);
    push_img(0, IMG_LEN);
    rst = 0;
    wait_settle("R1 power-up load");
    chk(busy == 0, "R1 busy after load", busy, 0);
    chk_state("R1", 0, 0, 0);

    // R5 normal request
    push_img(2, IMG_LEN);
    do_req(2);
    wait_settle("R5 load slot 2");
    chk_state("R5", 2, 0, 0);

    // R6 request during a load ignored
    push_img(3, IMG_LEN);
    do_req(3);
    repeat (6) @(negedge clk);
    do_req(1);
    wait_settle("R6 load slot 3");
    chk_state("R6", 3, 0, 0);

    // R8/R9 done never arrives on slot 1
    bad_done[1] = 1;
    push_img(1, IMG_LEN); push_img(0, IMG_LEN);
    do_req(1);
    wait_settle("R8 missing done");
    chk_state("R8/R9 fallback", 0, 1, 0);

    // R9 next request clears fell_back
    push_img(2, IMG_LEN);
    do_req(2);
    wait_settle("R9 clear");
    chk_state("R9 cleared", 2, 0, 0);

    // R8 done too late on slot 2
    late_done[2] = 1;
    push_img(2, IMG_LEN); push_img(0, IMG_LEN);
    do_req(2);
    wait_settle("R8 late done");
    chk_state("R8 late", 0, 1, 0);
    late_done[2] = 0;

    // R7 status drops after the fifth byte of slot 3
    bad_stat[3] = 1;
    push_img(3, 5); push_img(0, IMG_LEN);
    do_req(3);
    wait_settle("R7 status drop");
    chk_state("R7", 0, 1, 0);
    bad_stat[3] = 0;

    // R10 both slot 1 and safe slot fail
    bad_done[0] = 1;
    push_img(1, IMG_LEN); push_img(0, IMG_LEN);
    do_req(1);
    wait_settle("R10 fatal");
    chk(fatal == 1, "R10 fatal set", fatal, 1);
    chk(busy == 0, "R10 busy low", busy, 0);
    f0 = falls;
    do_req(2);
    repeat (60) @(negedge clk);
    chk(falls == f0, "R6/R10 no attempt when fatal", falls, f0);
    chk(fatal == 1, "R10 fatal sticky", fatal, 1);
    chk(exp_q.size() == 0, "R10 no bytes", exp_q.size(), 0);

    // R11 reset recovers
    bad_done[0] = 0; bad_done[1] = 0;
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    push_img(0, IMG_LEN);
    rst = 0;
    wait_settle("R11 reload");
    chk(busy == 0, "R11 busy", busy, 0);
    chk_state("R11", 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule